// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Detection

This block is one bank of general-purpose I/O pins with a register interface. Software drives output levels and chooses, pin by pin, whether the pad is driven or only observed. Each incoming pin level passes through a two-flop synchronizer. The synchronized levels can be read back, and they feed an interrupt detector for each pin. Each pin picks its own trigger: rising edge, falling edge, high level or low level.

Edge events are latched until software acknowledges them by writing ones to an acknowledge register. Level triggers are not latched: they follow the synchronized pin. A per-pin enable and a per-pin mask gate the raw detections into a masked view. The OR of that masked view drives one interrupt line for the whole bank. The handler reads the masked status, services each set bit and acknowledges the edge-triggered ones.

The bus is a simple single-cycle port. A write takes effect at the clock edge where `bus_valid` and `bus_write` are both high. A read issued in one cycle returns its data on `bus_rdata` after that same clock edge. The data stays there until the next read.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset the drive-data and drive-enable registers are zero, so `pin_out` and `pin_oe` are all zero. `irq` is low and the enable, mask, trigger-type and polarity registers read zero.
- R2: Register offsets are drive data 0x00, drive enable 0x04, irq enable 0x30, irq mask 0x34, trigger type 0x38, polarity 0x3C, masked status 0x40, raw status 0x44, acknowledge 0x4C and pin levels 0x50. `pin_out` follows the drive-data register. `pin_oe` follows the drive-enable register, where a 1 makes the pin an output. Both registers read back what was written.
- R3: Reading offset 0x50 returns the pin levels after a two-flop synchronizer. A level applied at least two clock edges before the read edge is returned.
- R4: A pin with trigger-type bit 1 and polarity bit 1 sets its raw-status bit on a rising edge of its synchronized level. The bit stays set after the pin falls again.
- R5: A pin with trigger-type bit 1 and polarity bit 0 sets its raw-status bit on a falling edge only. A rising edge leaves the bit clear.
- R6: A pin with trigger-type bit 0 has a raw-status bit equal to its synchronized level when its polarity bit is 1, and to the inverted level when its polarity bit is 0. Acknowledging such a pin has no effect.
- R7: Writing 1 to a bit of the acknowledge register clears that pin's latched edge. Writing 0 to a bit leaves it unchanged. The acknowledge register reads as zero.
- R8: The masked status equals raw status AND enable AND NOT mask. `irq` is the OR of all masked-status bits.
- R9: Writes to the masked-status, raw-status and pin-level offsets are ignored. Reads of offsets that hold no register, including 0x48 and 0x60, return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Read data, valid after the read edge |
| pin_in | input | NPINS | Asynchronous pin levels |
| pin_out | output | NPINS | Drive levels |
| pin_oe | output | NPINS | Drive enables, 1 = output |
| irq | output | 1 | Combined bank interrupt |

## Verification
The bench builds the bank with its default parameters: 32 pins and a two-stage synchronizer. With these values the full 32-bit register map is reachable, including the top bit 31 of every vector, which the rising-edge test exercises alongside bit 0. Because the synchronizer depth is two, the bench can wait a fixed settle time after each pin change. That time covers the synchronizer, the edge comparison and the status latch before any status is read.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int unsigned ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFF_DOUT  = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_DIR   = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_IEN   = 8'h30;
    localparam logic [ADDR_W-1:0] OFF_IMASK = 8'h34;
    localparam logic [ADDR_W-1:0] OFF_TRIG  = 8'h38;
    localparam logic [ADDR_W-1:0] OFF_POL   = 8'h3C;
    localparam logic [ADDR_W-1:0] OFF_MSTAT = 8'h40;
    localparam logic [ADDR_W-1:0] OFF_RSTAT = 8'h44;
    localparam logic [ADDR_W-1:0] OFF_ACK   = 8'h4C;
    localparam logic [ADDR_W-1:0] OFF_PINS  = 8'h50;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_DOUT, SEL_DIR, SEL_IEN, SEL_IMASK, SEL_TRIG,
        SEL_POL, SEL_MSTAT, SEL_RSTAT, SEL_ACK, SEL_PINS
    } reg_sel_e;

    typedef struct packed {
        logic     wr;
        logic     rd;
        reg_sel_e sel;
    } bus_cmd_t;

    function automatic reg_sel_e decode_offset(input logic [ADDR_W-1:0] a);
        case (a)
            OFF_DOUT:  return SEL_DOUT;
            OFF_DIR:   return SEL_DIR;
            OFF_IEN:   return SEL_IEN;
            OFF_IMASK: return SEL_IMASK;
            OFF_TRIG:  return SEL_TRIG;
            OFF_POL:   return SEL_POL;
            OFF_MSTAT: return SEL_MSTAT;
            OFF_RSTAT: return SEL_RSTAT;
            OFF_ACK:   return SEL_ACK;
            OFF_PINS:  return SEL_PINS;
            default:   return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] level_in,
    input  logic [WIDTH-1:0] trig_edge,
    input  logic [WIDTH-1:0] pol_high,
    input  logic [WIDTH-1:0] ack,
    output logic [WIDTH-1:0] raw
);
    logic [WIDTH-1:0] prev_q;
    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] evt;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= level_in;
    end

    for (genvar p = 0; p < WIDTH; p++) begin : g_pin
        logic rise, fall;
        assign rise   = level_in[p] & ~prev_q[p];
        assign fall   = ~level_in[p] & prev_q[p];
        assign evt[p] = pol_high[p] ? rise : fall;

        always_ff @(posedge clk) begin
            if (rst || !trig_edge[p]) latch_q[p] <= 1'b0;
            else if (evt[p])          latch_q[p] <= 1'b1;
            else if (ack[p])          latch_q[p] <= 1'b0;
        end

        assign raw[p] = trig_edge[p] ? latch_q[p]
                                     : (pol_high[p] ? level_in[p] : ~level_in[p]);
    end

    // R4
    edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((latch_q & trig_edge & ~ack) != '0) |=>
        ((latch_q & $past(latch_q & trig_edge & ~ack)) == $past(latch_q & trig_edge & ~ack)));

    // R7
    ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ((ack & trig_edge & ~evt) != '0) |=>
        ((latch_q & $past(ack & trig_edge & ~evt)) == '0));
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_bank_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_cmd_t         cmd,
    input  logic [WIDTH-1:0] wdata,
    input  logic [WIDTH-1:0] pins_sync,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] rdata,
    output logic [WIDTH-1:0] dout_o,
    output logic [WIDTH-1:0] dir_o,
    output logic [WIDTH-1:0] trig_o,
    output logic [WIDTH-1:0] pol_o,
    output logic [WIDTH-1:0] ack_o,
    output logic [WIDTH-1:0] masked_o,
    output logic [WIDTH-1:0] ien_o,
    output logic [WIDTH-1:0] imask_o
);
    logic [WIDTH-1:0] dout_q, dir_q, ien_q, imask_q, trig_q, pol_q, rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dout_q  <= '0;
            dir_q   <= '0;
            ien_q   <= '0;
            imask_q <= '0;
            trig_q  <= '0;
            pol_q   <= '0;
        end else if (cmd.wr) begin
            case (cmd.sel)
                SEL_DOUT:  dout_q  <= wdata;
                SEL_DIR:   dir_q   <= wdata;
                SEL_IEN:   ien_q   <= wdata;
                SEL_IMASK: imask_q <= wdata;
                SEL_TRIG:  trig_q  <= wdata;
                SEL_POL:   pol_q   <= wdata;
                default:   ;
            endcase
        end
    end

    assign masked_o = raw & ien_q & ~imask_q;
    assign ack_o    = (cmd.wr && cmd.sel == SEL_ACK) ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (cmd.rd) begin
            case (cmd.sel)
                SEL_DOUT:  rdata_q <= dout_q;
                SEL_DIR:   rdata_q <= dir_q;
                SEL_IEN:   rdata_q <= ien_q;
                SEL_IMASK: rdata_q <= imask_q;
                SEL_TRIG:  rdata_q <= trig_q;
                SEL_POL:   rdata_q <= pol_q;
                SEL_MSTAT: rdata_q <= masked_o;
                SEL_RSTAT: rdata_q <= raw;
                SEL_PINS:  rdata_q <= pins_sync;
                default:   rdata_q <= '0;
            endcase
        end
    end

    assign rdata   = rdata_q;
    assign dout_o  = dout_q;
    assign dir_o   = dir_q;
    assign trig_o  = trig_q;
    assign pol_o   = pol_q;
    assign ien_o   = ien_q;
    assign imask_o = imask_q;

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (dout_o == '0 && dir_o == '0 && ien_o == '0));

    // R2
    dir_write_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.wr && cmd.sel == SEL_DIR) |=> (dir_o == $past(wdata)));
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NPINS       = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq
);
    bus_cmd_t         cmd;
    logic [NPINS-1:0] pins_sync, raw, trig, pol, ack, masked, ien, imask;

    assign cmd.wr  = bus_valid & bus_write;
    assign cmd.rd  = bus_valid & ~bus_write;
    assign cmd.sel = decode_offset(bus_addr);

    gpio_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pins_sync)
    );

    gpio_irq_detect #(.WIDTH(NPINS)) u_detect (
        .clk       (clk),
        .rst       (rst),
        .level_in  (pins_sync),
        .trig_edge (trig),
        .pol_high  (pol),
        .ack       (ack),
        .raw       (raw)
    );

    gpio_regfile #(.WIDTH(NPINS)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .wdata     (bus_wdata),
        .pins_sync (pins_sync),
        .raw       (raw),
        .rdata     (bus_rdata),
        .dout_o    (pin_out),
        .dir_o     (pin_oe),
        .trig_o    (trig),
        .pol_o     (pol),
        .ack_o     (ack),
        .masked_o  (masked),
        .ien_o     (ien),
        .imask_o   (imask)
    );

    assign irq = |masked;

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((ien & ~imask & raw) != '0));
endmodule

// File: tb/gpio_irq_bank_tb.sv
`timescale 1ns/1ps
module gpio_irq_bank_tb;
    localparam int NP = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_valid = 1'b0;
    logic          bus_write = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [NP-1:0] bus_wdata = '0;
    logic [NP-1:0] bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out, pin_oe;
    logic          irq;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    gpio_irq_bank #(.NPINS(NP), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic check(input string req, input logic [NP-1:0] got, input logic [NP-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [NP-1:0] d);
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 0; bus_write = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [NP-1:0] d);
        @(negedge clk);
        bus_valid = 1; bus_write = 0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_valid = 0;
    endtask

    task automatic set_pins(input logic [NP-1:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic cfg(input logic [NP-1:0] t, input logic [NP-1:0] p,
                       input logic [NP-1:0] en, input logic [NP-1:0] m);
        wr(8'h38, t); wr(8'h3C, p); wr(8'h30, en); wr(8'h34, m);
    endtask

    task automatic t_reset();
        logic [NP-1:0] d;
        check("R1 pin_out", pin_out, '0);
        check("R1 pin_oe", pin_oe, '0);
        check("R1 irq", {31'b0, irq}, '0);
        rd(8'h00, d); check("R1 dout read", d, '0);
        rd(8'h04, d); check("R1 dir read", d, '0);
        rd(8'h30, d); check("R1 ien read", d, '0);
        rd(8'h38, d); check("R1 trig read", d, '0);
    endtask

    task automatic t_outputs();
        logic [NP-1:0] d;
        wr(8'h00, 32'hA5A5_0F0F);
        wr(8'h04, 32'hFFFF_0000);
        check("R2 pin_out", pin_out, 32'hA5A5_0F0F);
        check("R2 pin_oe", pin_oe, 32'hFFFF_0000);
        rd(8'h00, d); check("R2 dout readback", d, 32'hA5A5_0F0F);
        rd(8'h04, d); check("R2 dir readback", d, 32'hFFFF_0000);
        wr(8'h04, 32'h0000_00F1);
        check("R2 pin_oe second", pin_oe, 32'h0000_00F1);
    endtask

    task automatic t_pins();
        logic [NP-1:0] d;
        set_pins(32'h1234_5678);
        rd(8'h50, d); check("R3 pin levels a", d, 32'h1234_5678);
        set_pins(32'h8000_0001);
        rd(8'h50, d); check("R3 pin levels b", d, 32'h8000_0001);
        set_pins('0);
    endtask

    task automatic t_readonly();
        logic [NP-1:0] d;
        cfg('0, '0, '0, '0);
        set_pins(32'h0000_00C3);
        wr(8'h50, 32'hFFFF_FFFF);
        wr(8'h40, 32'hFFFF_FFFF);
        wr(8'h44, 32'h0);
        rd(8'h50, d); check("R9 pins write ignored", d, 32'h0000_00C3);
        rd(8'h40, d); check("R9 mstat write ignored", d, '0);
        rd(8'h44, d); check("R9 rstat write ignored", d, ~32'h0000_00C3);
        rd(8'h48, d); check("R9 0x48 reads zero", d, '0);
        rd(8'h60, d); check("R9 0x60 reads zero", d, '0);
        rd(8'h20, d); check("R9 unmapped reads zero", d, '0);
        rd(8'h4C, d); check("R7 ack reads zero", d, '0);
        set_pins('0);
    endtask

    task automatic t_rise();
        logic [NP-1:0] d;
        cfg(32'h8000_0001, 32'h8000_0001, 32'h8000_0001, '0);
        check("R4 no irq before edge", {31'b0, irq}, '0);
        set_pins(32'h8000_0001);
        check("R4 irq after rise", {31'b0, irq}, 1);
        rd(8'h44, d); check("R4 raw bits 0,31", d & 32'h8000_0001, 32'h8000_0001);
        set_pins('0);
        rd(8'h44, d); check("R4 raw held after fall", d & 32'h8000_0001, 32'h8000_0001);
    endtask

    task automatic t_ack();
        logic [NP-1:0] d;
        wr(8'h4C, 32'h0000_0002);
        rd(8'h44, d); check("R7 zero bits leave latch", d & 32'h8000_0001, 32'h8000_0001);
        wr(8'h4C, 32'h0000_0001);
        rd(8'h44, d); check("R7 bit0 cleared", d & 32'h8000_0001, 32'h8000_0000);
        wr(8'h4C, 32'h8000_0000);
        rd(8'h44, d); check("R7 bit31 cleared", d & 32'h8000_0001, '0);
        check("R7 irq low after acks", {31'b0, irq}, '0);
    endtask

    task automatic t_fall();
        logic [NP-1:0] d;
        cfg(32'h0000_0002, 32'h0, 32'h0000_0002, '0);
        set_pins(32'h0000_0002);
        rd(8'h44, d); check("R5 rise ignored", d & 32'h2, '0);
        check("R5 no irq on rise", {31'b0, irq}, '0);
        set_pins('0);
        rd(8'h44, d); check("R5 fall latched", d & 32'h2, 32'h2);
        check("R5 irq on fall", {31'b0, irq}, 1);
        wr(8'h4C, 32'h2);
    endtask

    task automatic t_level();
        logic [NP-1:0] d;
        cfg(32'h0, 32'h0000_0004, 32'h0000_000C, '0);
        rd(8'h44, d); check("R6 high-level idle", d & 32'hC, 32'h8);
        set_pins(32'h0000_000C);
        rd(8'h44, d); check("R6 levels follow pins", d & 32'hC, 32'h4);
        wr(8'h4C, 32'h0000_000C);
        rd(8'h44, d); check("R6 ack no effect", d & 32'hC, 32'h4);
        check("R6 irq from level", {31'b0, irq}, 1);
        set_pins(32'h0000_0008);
        rd(8'h44, d); check("R6 level drop", d & 32'hC, 32'h0);
        check("R6 irq drops", {31'b0, irq}, '0);
    endtask

    task automatic t_mask();
        logic [NP-1:0] d;
        cfg(32'h0, 32'h0000_0004, 32'h0000_0004, 32'h0000_0004);
        set_pins(32'h0000_0004);
        rd(8'h40, d); check("R8 masked by mask", d, '0);
        check("R8 irq masked", {31'b0, irq}, '0);
        wr(8'h34, '0);
        rd(8'h40, d); check("R8 mstat unmasked", d, 32'h0000_0004);
        check("R8 irq unmasked", {31'b0, irq}, 1);
        wr(8'h30, '0);
        rd(8'h40, d); check("R8 disabled", d, '0);
        check("R8 irq disabled", {31'b0, irq}, '0);
        set_pins('0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_outputs();
        t_pins();
        t_readonly();
        t_rise();
        t_ack();
        t_fall();
        t_level();
        t_mask();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog got=timeout exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule